// File: doc/BRIEF.md
# Sector Erase Command Accumulator

This block sits in front of a flash erase engine. It watches a simple asynchronous-style write port made of an active-low write enable, an active-low chip enable, an address and a data bus, all sampled on the system clock. A write starts when both enables are low. It completes when either enable returns high. When upstream command decoding reports that the erase setup has been seen, the first completed write opens a collection window. Each later completed write adds the sector chosen by the upper address bits to an erase-select bitmap, and it also restarts the window.

The window timer counts only while no write is in progress. It starts from the end of the most recent write. When it runs out, the block raises a one-cycle start pulse toward the erase engine and sets a status bit telling software that no more sectors are accepted. The bitmap then stays frozen until the engine reports completion. A write whose data is the suspend code is not treated as a sector. It either cuts the window short or, while the erase runs, is passed to the engine as a suspend request. A synchronous reset input clears everything at once.

Top module: `sector_erase_accum`

## Requirements
- R1: While `rst` is high at a clock edge, the following are all zero after that edge: `sectorMap`, `timerExpired`, `eraseStart` and `suspendReq`. This holds in every state, including in the middle of an open window.
- R2: When no window is open, a completed write opens the window and sets bit `addr[ADDR_W-1 -: SEC_W]` of `sectorMap` only if `setupSeen` was high at the start of that write. If it was low, the write changes nothing.
- R3: While the window is open, every completed write whose data is not `SUSPEND_CODE` (default 8'hB0) sets the bit of its sector. The data value is not otherwise looked at. Sectors may arrive in any order, and repeating a sector changes nothing.
- R4: `timerExpired` rises exactly `WINDOW_CYC` clock cycles after the edge on which the end of the last write is seen. `WINDOW_CYC` is `ceil(CLK_HZ * WINDOW_NS / 1e9)`, which gives 4000 at the 50 MHz and 80000 ns defaults.
- R5: A write that starts while the window is open holds the timer at zero. Counting starts again from the end of that write, so the window is extended.
- R6: `eraseStart` is a single-cycle pulse. It is asserted together with the rising edge of `timerExpired`, and `sectorMap` holds the collected sectors at that time.
- R7: After the window ends, completed writes leave `sectorMap` unchanged until `eraseDone` is seen. `eraseDone` then clears `sectorMap` and `timerExpired` on the next edge, and the block is ready for a new window.
- R8: A completed write of `SUSPEND_CODE` during the window ends the window on that edge. `eraseStart`, `suspendReq` and `timerExpired` all assert, and the address of the suspend write is not added to `sectorMap`.
- R9: A completed write of `SUSPEND_CODE` after the window has ended gives a one-cycle `suspendReq` pulse and leaves `sectorMap` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| weN | input | 1 | Write enable, active low |
| ceN | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Write address; the upper SEC_W bits pick the sector |
| data | input | DATA_W | Write data, compared only against the suspend code |
| setupSeen | input | 1 | Erase unlock and setup sequence already decoded upstream |
| eraseDone | input | 1 | Erase engine has finished; releases the bitmap |
| sectorMap | output | 2**SEC_W | Erase-select bitmap, one bit per sector |
| eraseStart | output | 1 | One-cycle pulse that hands the bitmap to the engine |
| timerExpired | output | 1 | High once the collection window has closed |
| suspendReq | output | 1 | One-cycle suspend request toward the engine |

## Verification
The hardest case to reach from the ports is the retrigger. To show that the window was restarted, a second write has to land late in the first window, and expiry must then be timed from the end of that write and not from the first. The stimulus opens a window, waits 3000 of the 4000 cycles, writes again, and then samples `timerExpired` exactly one cycle before and on the expected edge. At that point the total time since the first write is far beyond one window. The suspend write that arrives inside the window is driven the same way. It is checked on the edge where it ends, to confirm that the start pulse, the suspend pulse and the status bit all coincide and that its address was not added.

// File: rtl/secacc_pkg.sv
package secacc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_EXEC   = 2'd2
  } accState_t;

  typedef struct packed {
    logic setBit;
    logic clearMap;
    logic clearTimer;
    logic runTimer;
  } ctrlStrobe_t;

endpackage

// File: rtl/secacc_dpath.sv
module secacc_dpath
  import secacc_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int SEC_W        = 4,
  parameter int WINDOW_CYC   = 4000,
  parameter logic [DATA_W-1:0] SUSPEND_CODE = 8'hB0,
  localparam int NUM_SEC     = 1 << SEC_W,
  localparam int TIMER_W     = $clog2(WINDOW_CYC + 1),
  localparam int SEC_SHIFT   = ADDR_W - SEC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               weN,
  input  logic               ceN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  input  logic               setupSeen,
  input  ctrlStrobe_t        strb,
  output logic               startEdge,
  output logic               endEdge,
  output logic               wrBusy,
  output logic               setupHold,
  output logic               suspendHit,
  output logic               timerHit,
  output logic [NUM_SEC-1:0] sectorMap
);

  logic               wrAct;
  logic               wrPrev;
  logic [ADDR_W-1:0]  addrHold;
  logic [DATA_W-1:0]  dataHold;
  logic [SEC_W-1:0]   secIdx;
  logic [TIMER_W-1:0] count;

  // Strobe edge detection: a write is active while both enables are low.
  assign wrAct     = ~weN & ~ceN;
  assign startEdge = wrAct & ~wrPrev;
  assign endEdge   = ~wrAct & wrPrev;
  assign wrBusy    = wrAct | wrPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPrev    <= 1'b0;
      addrHold  <= '0;
      dataHold  <= '0;
      setupHold <= 1'b0;
    end else begin
      wrPrev <= wrAct;
      if (startEdge) begin
        addrHold  <= addr;
        dataHold  <= data;
        setupHold <= setupSeen;
      end
    end
  end

  assign secIdx     = SEC_W'(addrHold >> SEC_SHIFT);
  assign suspendHit = (dataHold == SUSPEND_CODE);

  // Retriggerable window timer.
  always_ff @(posedge clk) begin
    if (rst || strb.clearTimer) begin
      count <= '0;
    end else if (strb.runTimer && !timerHit) begin
      count <= count + 1'b1;
    end
  end

  assign timerHit = (count == TIMER_W'(WINDOW_CYC - 1));

  // Sector select bitmap.
  always_ff @(posedge clk) begin
    if (rst || strb.clearMap) begin
      sectorMap <= '0;
    end else if (strb.setBit) begin
      sectorMap <= sectorMap | (NUM_SEC'(1) << secIdx);
    end
  end

endmodule

// File: rtl/secacc_ctrl.sv
module secacc_ctrl
  import secacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startEdge,
  input  logic        endEdge,
  input  logic        wrBusy,
  input  logic        setupHold,
  input  logic        suspendHit,
  input  logic        timerHit,
  input  logic        eraseDone,
  output ctrlStrobe_t strb,
  output logic        eraseStart,
  output logic        suspendReq,
  output logic        timerExpired
);

  accState_t state;
  accState_t stateNext;
  logic      startNext;
  logic      suspNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    startNext = 1'b0;
    suspNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (endEdge && setupHold) begin
          strb.setBit     = 1'b1;
          strb.clearTimer = 1'b1;
          stateNext       = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (endEdge) begin
          if (suspendHit) begin
            stateNext = ST_EXEC;
            startNext = 1'b1;
            suspNext  = 1'b1;
          end else begin
            strb.setBit     = 1'b1;
            strb.clearTimer = 1'b1;
          end
        end else if (startEdge || wrBusy) begin
          strb.clearTimer = 1'b1;
        end else if (timerHit) begin
          stateNext = ST_EXEC;
          startNext = 1'b1;
        end else begin
          strb.runTimer = 1'b1;
        end
      end
      ST_EXEC: begin
        if (eraseDone) begin
          strb.clearMap   = 1'b1;
          strb.clearTimer = 1'b1;
          stateNext       = ST_IDLE;
        end else if (endEdge && suspendHit) begin
          suspNext = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      eraseStart <= 1'b0;
      suspendReq <= 1'b0;
    end else begin
      state      <= stateNext;
      eraseStart <= startNext;
      suspendReq <= suspNext;
    end
  end

  assign timerExpired = (state == ST_EXEC);

endmodule

// File: rtl/sector_erase_accum.sv
module sector_erase_accum
  import secacc_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int WINDOW_NS  = 80_000,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int SEC_W      = 4,
  parameter logic [DATA_W-1:0] SUSPEND_CODE = 8'hB0,
  localparam int NUM_SEC   = 1 << SEC_W,
  localparam longint WIN_PROD = longint'(CLK_HZ) * longint'(WINDOW_NS),
  localparam int WIN_RAW   = int'((WIN_PROD + 64'sd999_999_999) / 64'sd1_000_000_000),
  localparam int WINDOW_CYC = (WIN_RAW < 2) ? 2 : WIN_RAW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               weN,
  input  logic               ceN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  input  logic               setupSeen,
  input  logic               eraseDone,
  output logic [NUM_SEC-1:0] sectorMap,
  output logic               eraseStart,
  output logic               timerExpired,
  output logic               suspendReq
);

  ctrlStrobe_t strb;
  logic startEdge, endEdge, wrBusy, setupHold, suspendHit, timerHit;

  secacc_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W),
    .WINDOW_CYC(WINDOW_CYC), .SUSPEND_CODE(SUSPEND_CODE)
  ) uDpath (
    .clk(clk), .rst(rst), .weN(weN), .ceN(ceN), .addr(addr), .data(data),
    .setupSeen(setupSeen), .strb(strb), .startEdge(startEdge),
    .endEdge(endEdge), .wrBusy(wrBusy), .setupHold(setupHold),
    .suspendHit(suspendHit), .timerHit(timerHit), .sectorMap(sectorMap)
  );

  secacc_ctrl uCtrl (
    .clk(clk), .rst(rst), .startEdge(startEdge), .endEdge(endEdge),
    .wrBusy(wrBusy), .setupHold(setupHold), .suspendHit(suspendHit),
    .timerHit(timerHit), .eraseDone(eraseDone), .strb(strb),
    .eraseStart(eraseStart), .suspendReq(suspendReq),
    .timerExpired(timerExpired)
  );

endmodule

// File: rtl/sector_erase_accum_chk.sv
module sector_erase_accum_chk #(
  parameter int NUM_SEC = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               eraseDone,
  input logic [NUM_SEC-1:0] sectorMap,
  input logic               eraseStart,
  input logic               timerExpired,
  input logic               suspendReq
);

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sectorMap == '0) && !timerExpired && !eraseStart && !suspendReq);

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    eraseStart |=> !eraseStart);

  // R6
  start_with_status_chk: assert property (@(posedge clk) disable iff (rst)
    eraseStart |-> $rose(timerExpired));

  // R7
  map_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (timerExpired && !eraseDone) |=> $stable(sectorMap));

  // R3
  bits_only_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!eraseDone && !$past(rst)) |=> ((sectorMap & $past(sectorMap)) == $past(sectorMap)));

  // R9
  suspend_when_closed_chk: assert property (@(posedge clk) disable iff (rst)
    suspendReq |-> timerExpired);

endmodule

bind sector_erase_accum sector_erase_accum_chk #(.NUM_SEC(NUM_SEC)) uChk (
  .clk(clk), .rst(rst), .eraseDone(eraseDone), .sectorMap(sectorMap),
  .eraseStart(eraseStart), .timerExpired(timerExpired), .suspendReq(suspendReq)
);

// File: tb/tb_sector_erase_accum.sv
module tb_sector_erase_accum;

  localparam int WIN = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        weN = 1'b1;
  logic        ceN = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  data = '0;
  logic        setupSeen = 1'b0;
  logic        eraseDone = 1'b0;
  logic [15:0] sectorMap;
  logic        eraseStart, timerExpired, suspendReq;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sector_erase_accum dut (
    .clk(clk), .rst(rst), .weN(weN), .ceN(ceN), .addr(addr), .data(data),
    .setupSeen(setupSeen), .eraseDone(eraseDone), .sectorMap(sectorMap),
    .eraseStart(eraseStart), .timerExpired(timerExpired), .suspendReq(suspendReq)
  );

  // {addr[11:0], data[7:0], expected map[15:0]}
  localparam logic [35:0] VEC [7] = '{
    {12'h3A5, 8'h30, 16'h0008},
    {12'h000, 8'h55, 16'h0009},
    {12'hF00, 8'hFF, 16'h8009},
    {12'h3FF, 8'h00, 16'h8009},
    {12'h7C1, 8'hB1, 16'h8089},
    {12'h1E0, 8'h30, 16'h808B},
    {12'hC3C, 8'hA0, 16'h908B}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Returns at the negedge just after the edge that sees the end of the write.
  task automatic doWrite(input logic [11:0] a, input logic [7:0] d, input logic s);
    @(negedge clk);
    addr = a; data = d; setupSeen = s; weN = 1'b0; ceN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doneEngine();
    @(negedge clk); eraseDone = 1'b1;
    @(negedge clk); eraseDone = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    waitCyc(3);
    // R1 reset state
    check("R1 map after reset", 32'(sectorMap), 32'h0);
    check("R1 status after reset", 32'(timerExpired), 32'h0);
    check("R1 start after reset", 32'(eraseStart), 32'h0);
    check("R1 suspend after reset", 32'(suspendReq), 32'h0);
    @(negedge clk); rst = 1'b0;

    // R2 write without setup seen is ignored
    doWrite(12'h500, 8'h30, 1'b0);
    check("R2 no setup map", 32'(sectorMap), 32'h0);
    waitCyc(10);
    check("R2 no setup status", 32'(timerExpired), 32'h0);

    // R2/R3 vector walk within one window
    foreach (VEC[i]) begin
      doWrite(VEC[i][35:24], VEC[i][23:16], 1'b1);
      check($sformatf("R3 vector %0d map", i), 32'(sectorMap), 32'(VEC[i][15:0]));
      check($sformatf("R3 vector %0d open", i), 32'(timerExpired), 32'h0);
    end

    // R4 exact expiry, R6 start pulse
    waitCyc(WIN - 1);
    check("R4 status one cycle before expiry", 32'(timerExpired), 32'h0);
    check("R6 no start before expiry", 32'(eraseStart), 32'h0);
    waitCyc(1);
    check("R4 status at expiry", 32'(timerExpired), 32'h1);
    check("R6 start at expiry", 32'(eraseStart), 32'h1);
    check("R6 map at start", 32'(sectorMap), 32'h908B);
    waitCyc(1);
    check("R6 start single cycle", 32'(eraseStart), 32'h0);

    // R7 writes after expiry ignored
    doWrite(12'h200, 8'h30, 1'b1);
    check("R7 map frozen", 32'(sectorMap), 32'h908B);
    check("R7 status held", 32'(timerExpired), 32'h1);

    // R9 suspend while erasing
    doWrite(12'h400, 8'hB0, 1'b1);
    check("R9 suspend pulse", 32'(suspendReq), 32'h1);
    check("R9 map unchanged", 32'(sectorMap), 32'h908B);
    waitCyc(1);
    check("R9 suspend single cycle", 32'(suspendReq), 32'h0);

    // R7 engine done releases
    doneEngine();
    check("R7 map cleared by done", 32'(sectorMap), 32'h0);
    check("R7 status cleared by done", 32'(timerExpired), 32'h0);

    // R5 retrigger late in the window
    doWrite(12'h400, 8'h30, 1'b1);
    waitCyc(3000);
    doWrite(12'h600, 8'h30, 1'b0);
    waitCyc(WIN - 1);
    check("R5 still open after restart", 32'(timerExpired), 32'h0);
    waitCyc(1);
    check("R5 expiry from last write", 32'(timerExpired), 32'h1);
    check("R5 map both sectors", 32'(sectorMap), 32'h0050);
    doneEngine();

    // R8 suspend inside the window
    doWrite(12'h800, 8'h12, 1'b1);
    doWrite(12'hA00, 8'hB0, 1'b1);
    check("R8 start on suspend", 32'(eraseStart), 32'h1);
    check("R8 suspend pulse", 32'(suspendReq), 32'h1);
    check("R8 status closed", 32'(timerExpired), 32'h1);
    check("R8 suspend address not added", 32'(sectorMap), 32'h0100);
    doneEngine();

    // R1 reset in the middle of a window
    doWrite(12'hB00, 8'h30, 1'b1);
    check("R1 window opened", 32'(sectorMap), 32'h0800);
    waitCyc(100);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 map cleared mid window", 32'(sectorMap), 32'h0);
    waitCyc(WIN + 5);
    check("R1 no expiry after reset", 32'(timerExpired), 32'h0);

    finish();
  end

endmodule